// File: doc/BRIEF.md
# Posted-Write Fault Status Capture

This block keeps a record of faults raised by posted bus transactions that finish after the issuing processor has moved on. Each finished transaction arrives as a one-cycle completion event that carries its outcome, its size, the processor mode, a read/write flag and its physical address. Two outcomes count as faults: an error reported after the transfer ended, and an error acknowledge. A third kind of fault comes from inside the block. A watchdog times every outstanding write, and it flags the write as stalled when no completion arrives within a fixed wall-clock limit. The limit is turned into clock cycles from a clock-frequency parameter.

Only the first fault is recorded in detail: its cause bit, size, mode, read flag and address. Any fault that arrives while a record is held sets only a multiple-error flag. Software reads a 32-bit status word and a fault-address word. A summary error bit drives the interrupt line. Software clears the record by writing to the status register.

Top module: `afs_fault_capture`

## Requirements
- R1: After reset, `status` is 0x0080_0000, `fault_addr` is 0 and `irq` is 0.
- R2: `status[23:20]` always reads 4'h8, and `status[16:0]` always reads 0.
- R3: A completion event sampled with `cpl_kind` 2'b01 (late error) sets `status[30]`, and one with 2'b10 (error acknowledge) sets `status[28]`. Kinds 2'b00 (normal) and 2'b11 (reserved) record nothing. The change is visible right after the sampling edge.
- R4: The first recorded fault loads its size into `status[27:25]`, its supervisor flag into `status[24]` and its read flag into `status[18]`. It also sets `status[17]` (address valid) and loads its address into `fault_addr`.
- R5: The timeout limit is LIMIT = CLK_HZ*TIMEOUT_NS/10^9 cycles, which is 320 at the defaults. Suppose a write is started by `wr_start` at edge E0 and none of the edges E1..E_LIMIT carries a write completion. Then right after E_LIMIT a timeout fault is recorded: `status[29]` is set, together with the start's size, mode and address, and with the read flag 0.
- R6: Any completion event with `cpl_read`=0 ends the outstanding write, and no timeout follows. A completion with `cpl_read`=1 does not end it. A new `wr_start` restarts the timer with new attributes.
- R7: A fault that arrives while `status[17]` is set changes nothing except setting `status[19]`. When a completion fault and a timeout arrive at the same edge with no record held, the completion is recorded and `status[19]` is set.
- R8: A sampled `sw_wr` clears `status[31:24]` and `status[19:17]` and leaves `fault_addr` unchanged. A fault at the same edge is recorded as a first fault, with `status[19]` left at 0.
- R9: `status[31]` is the OR of `status[30:28]`, and `irq` equals `status[31]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_start | input | 1 | A posted write begins; its attributes are captured for the timer |
| wr_size | input | 3 | Size code of the starting write |
| wr_super | input | 1 | Supervisor flag of the starting write |
| wr_addr | input | 32 | Physical address of the starting write |
| cpl_valid | input | 1 | Completion event strobe |
| cpl_kind | input | 2 | Outcome: 00 normal, 01 late error, 10 error acknowledge, 11 reserved |
| cpl_size | input | 3 | Size code of the completing transaction |
| cpl_super | input | 1 | Supervisor flag of the completing transaction |
| cpl_read | input | 1 | 1 when the completing transaction was a read |
| cpl_addr | input | 32 | Physical address of the completing transaction |
| sw_wr | input | 1 | Software write to the status register (clears the record) |
| status | output | 32 | Fault status word |
| fault_addr | output | 32 | Address of the first recorded fault |
| irq | output | 1 | Interrupt, equal to the summary error bit |

## Verification
Completion faults, clears and multiple-error updates are due one edge after the event is sampled. The bench drives every input on the falling edge and reads the outputs on the next falling edge, so each check lands exactly one rising edge after its stimulus. Timeouts are due on the LIMIT-th edge after the start. The bench counts edges from the start and checks both the edge just before the limit and the edge at it. Completions are placed on every edge from 1 to LIMIT to confirm that none of them lets a timeout through.

// File: rtl/afs_pkg.sv
// Package: shared types and constants for the posted-write fault capture.
// Assumes a 32-bit status word whose bit positions are fixed by software.
package afs_pkg;
    parameter int unsigned AFS_AW = 32;   // physical address width
    parameter int unsigned AFS_SW = 3;    // transaction size code width

    typedef enum logic [1:0] {
        CPL_OK     = 2'b00,
        CPL_LATE   = 2'b01,
        CPL_ACKERR = 2'b10,
        CPL_RSVD   = 2'b11
    } cpl_kind_e;

    // One fault as seen by the recorder
    typedef struct packed {
        logic              late;
        logic              tmo;
        logic              ack;
        logic [AFS_SW-1:0] size;
        logic              sup;
        logic              rd;
        logic [AFS_AW-1:0] addr;
    } fault_rec_t;

    // Recorder state
    typedef struct packed {
        logic              late;
        logic              tmo;
        logic              ack;
        logic [AFS_SW-1:0] size;
        logic              sup;
        logic              multi;
        logic              rd;
        logic              valid;
        logic [AFS_AW-1:0] addr;
    } fault_state_t;

    localparam logic [3:0] RESV_VALUE = 4'h8;
endpackage

// File: rtl/afs_timer.sv
// Module: write stall timer. It times one outstanding posted write and
// holds that write's attributes. It fires once when LIMIT edges pass
// with no write completion. Assumes at most one write is outstanding;
// a new start replaces the old one.
module afs_timer
    import afs_pkg::*;
#(
    parameter int unsigned LIMIT = 320
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [AFS_SW-1:0] start_size_i,
    input  logic              start_sup_i,
    input  logic [AFS_AW-1:0] start_addr_i,
    input  logic              end_i,
    output logic              fire_o,
    output logic [AFS_SW-1:0] size_o,
    output logic              sup_o,
    output logic [AFS_AW-1:0] addr_o
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic          busy;
    logic [CW-1:0] age;

    // Fire when the write has aged to the limit without ending or restarting
    assign fire_o = busy && !start_i && !end_i && (age == LAST);

    // Track the outstanding write and its age in cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            age    <= '0;
            size_o <= '0;
            sup_o  <= 1'b0;
            addr_o <= '0;
        end else if (start_i) begin
            busy   <= 1'b1;
            age    <= '0;
            size_o <= start_size_i;
            sup_o  <= start_sup_i;
            addr_o <= start_addr_i;
        end else if (busy) begin
            if (end_i || age == LAST) begin
                busy <= 1'b0;
            end else begin
                age <= age + 1'b1;
            end
        end
    end
endmodule

// File: rtl/afs_merge.sv
// Module: fault merger. It turns a completion event and a timer fire into
// one fault record for the recorder. A completion fault wins over a
// simultaneous timeout, and the pair is flagged as a double. Purely
// combinational.
module afs_merge
    import afs_pkg::*;
(
    input  logic              cpl_valid_i,
    input  cpl_kind_e         cpl_kind_i,
    input  logic [AFS_SW-1:0] cpl_size_i,
    input  logic              cpl_sup_i,
    input  logic              cpl_rd_i,
    input  logic [AFS_AW-1:0] cpl_addr_i,
    input  logic              to_fire_i,
    input  logic [AFS_SW-1:0] to_size_i,
    input  logic              to_sup_i,
    input  logic [AFS_AW-1:0] to_addr_i,
    output logic              hit_o,
    output logic              dual_o,
    output fault_rec_t        rec_o
);
    logic cpl_fault;

    // A completion is a fault only for the two error kinds
    assign cpl_fault = cpl_valid_i &&
                       (cpl_kind_i == CPL_LATE || cpl_kind_i == CPL_ACKERR);
    assign hit_o  = cpl_fault || to_fire_i;
    assign dual_o = cpl_fault && to_fire_i;

    // Pick the record to offer, completion first
    always_comb begin
        if (cpl_fault) begin
            rec_o.late = (cpl_kind_i == CPL_LATE);
            rec_o.tmo  = 1'b0;
            rec_o.ack  = (cpl_kind_i == CPL_ACKERR);
            rec_o.size = cpl_size_i;
            rec_o.sup  = cpl_sup_i;
            rec_o.rd   = cpl_rd_i;
            rec_o.addr = cpl_addr_i;
        end else begin
            rec_o.late = 1'b0;
            rec_o.tmo  = 1'b1;
            rec_o.ack  = 1'b0;
            rec_o.size = to_size_i;
            rec_o.sup  = to_sup_i;
            rec_o.rd   = 1'b0;
            rec_o.addr = to_addr_i;
        end
    end
endmodule

// File: rtl/afs_recorder.sv
// Module: sticky fault recorder. It keeps the first fault in detail and
// marks any later one in the multiple flag. A software clear is applied
// before a fault at the same edge, so that fault is recorded as first.
// The address survives a clear.
module afs_recorder
    import afs_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit_i,
    input  logic         dual_i,
    input  fault_rec_t   rec_i,
    input  logic         clr_i,
    output fault_state_t st_o
);
    fault_state_t nxt;

    // Next state: clear first, then record or flag the incoming fault
    always_comb begin
        nxt = st_o;
        if (clr_i) begin
            nxt.late  = 1'b0;
            nxt.tmo   = 1'b0;
            nxt.ack   = 1'b0;
            nxt.size  = '0;
            nxt.sup   = 1'b0;
            nxt.multi = 1'b0;
            nxt.rd    = 1'b0;
            nxt.valid = 1'b0;
        end
        if (hit_i) begin
            if (nxt.valid) begin
                nxt.multi = 1'b1;
            end else begin
                nxt.late  = rec_i.late;
                nxt.tmo   = rec_i.tmo;
                nxt.ack   = rec_i.ack;
                nxt.size  = rec_i.size;
                nxt.sup   = rec_i.sup;
                nxt.rd    = rec_i.rd;
                nxt.addr  = rec_i.addr;
                nxt.valid = 1'b1;
                nxt.multi = dual_i;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_o <= '0;
        end else begin
            st_o <= nxt;
        end
    end
endmodule

// File: rtl/afs_fault_capture.sv
// Module: top of the posted-write fault capture. It wires the stall timer,
// the fault merger and the recorder, and it packs the status word.
// Assumes the completion and start strobes are one cycle wide and
// synchronous to clk. The timeout limit comes from CLK_HZ and TIMEOUT_NS.
module afs_fault_capture
    import afs_pkg::*;
#(
    parameter longint unsigned CLK_HZ     = 25_000_000,
    parameter longint unsigned TIMEOUT_NS = 12_800
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_start,
    input  logic [2:0]  wr_size,
    input  logic        wr_super,
    input  logic [31:0] wr_addr,
    input  logic        cpl_valid,
    input  logic [1:0]  cpl_kind,
    input  logic [2:0]  cpl_size,
    input  logic        cpl_super,
    input  logic        cpl_read,
    input  logic [31:0] cpl_addr,
    input  logic        sw_wr,
    output logic [31:0] status,
    output logic [31:0] fault_addr,
    output logic        irq
);
    localparam longint unsigned LIMIT_L = (CLK_HZ * TIMEOUT_NS) / 64'd1_000_000_000;
    localparam int unsigned     LIMIT   = (LIMIT_L < 1) ? 1 : int'(LIMIT_L);

    logic              to_fire;
    logic [AFS_SW-1:0] to_size;
    logic              to_sup;
    logic [AFS_AW-1:0] to_addr;
    logic              write_end;
    logic              hit;
    logic              dual;
    fault_rec_t        rec;
    fault_state_t      st;
    logic              err_sum;

    // Any write completion ends the timed write
    assign write_end = cpl_valid && !cpl_read;

    afs_timer #(.LIMIT(LIMIT)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (wr_start),
        .start_size_i (wr_size),
        .start_sup_i  (wr_super),
        .start_addr_i (wr_addr),
        .end_i        (write_end),
        .fire_o       (to_fire),
        .size_o       (to_size),
        .sup_o        (to_sup),
        .addr_o       (to_addr)
    );

    afs_merge u_merge (
        .cpl_valid_i (cpl_valid),
        .cpl_kind_i  (cpl_kind_e'(cpl_kind)),
        .cpl_size_i  (cpl_size),
        .cpl_sup_i   (cpl_super),
        .cpl_rd_i    (cpl_read),
        .cpl_addr_i  (cpl_addr),
        .to_fire_i   (to_fire),
        .to_size_i   (to_size),
        .to_sup_i    (to_sup),
        .to_addr_i   (to_addr),
        .hit_o       (hit),
        .dual_o      (dual),
        .rec_o       (rec)
    );

    afs_recorder u_rec (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (hit),
        .dual_i (dual),
        .rec_i  (rec),
        .clr_i  (sw_wr),
        .st_o   (st)
    );

    // Pack the status word and drive the interrupt
    assign err_sum    = st.late | st.tmo | st.ack;
    assign status     = {err_sum, st.late, st.tmo, st.ack, st.size, st.sup,
                         RESV_VALUE, st.multi, st.rd, st.valid, 17'd0};
    assign fault_addr = st.addr;
    assign irq        = err_sum;
endmodule

// File: rtl/afs_fault_capture_chk.sv
// Checker: temporal properties of the fault capture, bound to the top.
// It keeps its own write-age counter so that it can check the timeout window.
module afs_fault_capture_chk #(
    parameter int unsigned LIMIT = 320
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_start,
    input logic        write_end,
    input logic        to_fire,
    input logic        hit,
    input logic        sw_wr,
    input logic [31:0] status,
    input logic [31:0] fault_addr,
    input logic        irq
);
    logic        c_busy;
    int unsigned c_age;

    // Independent age of the outstanding write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_busy <= 1'b0;
            c_age  <= 0;
        end else if (wr_start) begin
            c_busy <= 1'b1;
            c_age  <= 0;
        end else if (c_busy) begin
            if (write_end || to_fire) c_busy <= 1'b0;
            else c_age <= c_age + 1;
        end
    end

    // R5: a timeout fires only on the limit edge of a live write
    a_r5_timeout_window: assert property (@(posedge clk) disable iff (!rst_n)
        to_fire |-> (c_busy && c_age == LIMIT - 1));

    // R7: while a record is held and no clear comes, its details stay put
    a_r7_record_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (status[17] && !sw_wr) |=> ($stable(fault_addr) && $stable(status[31:24])
                                    && $stable(status[18:17])));

    // R8: a clear with no fault empties the sticky bits
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && !hit) |=> (status[31:24] == 8'h00 && status[19:17] == 3'b000));

    // R7: the multiple flag appears only with a held record
    a_r7_multi_needs_err: assert property (@(posedge clk) disable iff (!rst_n)
        status[19] |-> (status[31] && status[17]));

    // R9: interrupt tracks the summary bit
    a_r9_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq == status[31]);

    // R2: reserved field constant
    a_r2_resv: assert property (@(posedge clk) disable iff (!rst_n)
        status[23:20] == 4'h8 && status[16:0] == 17'd0);
endmodule

bind afs_fault_capture afs_fault_capture_chk #(.LIMIT(LIMIT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_start   (wr_start),
    .write_end  (write_end),
    .to_fire    (to_fire),
    .hit        (hit),
    .sw_wr      (sw_wr),
    .status     (status),
    .fault_addr (fault_addr),
    .irq        (irq)
);

// File: tb/afs_fault_capture_tb.sv
// Bench: sweeps every completion kind, size, mode and read flag, every
// completion edge within the timeout window, and the multiple-fault and
// clear corners. Expected words are built arithmetically from the field layout.
module afs_fault_capture_tb;
    localparam longint unsigned CLK_HZ = 25_000_000;
    localparam longint unsigned TO_NS  = 400;
    localparam int LIM = int'((CLK_HZ / 1000) * TO_NS / 1_000_000);  // 10

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_start = 1'b0;
    logic [2:0]  wr_size = '0;
    logic        wr_super = 1'b0;
    logic [31:0] wr_addr = '0;
    logic        cpl_valid = 1'b0;
    logic [1:0]  cpl_kind = '0;
    logic [2:0]  cpl_size = '0;
    logic        cpl_super = 1'b0;
    logic        cpl_read = 1'b0;
    logic [31:0] cpl_addr = '0;
    logic        sw_wr = 1'b0;
    logic [31:0] status;
    logic [31:0] fault_addr;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] last_addr = '0;

    always #10 clk = ~clk;

    afs_fault_capture #(.CLK_HZ(CLK_HZ), .TIMEOUT_NS(TO_NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_size(wr_size),
        .wr_super(wr_super), .wr_addr(wr_addr), .cpl_valid(cpl_valid),
        .cpl_kind(cpl_kind), .cpl_size(cpl_size), .cpl_super(cpl_super),
        .cpl_read(cpl_read), .cpl_addr(cpl_addr), .sw_wr(sw_wr),
        .status(status), .fault_addr(fault_addr), .irq(irq)
    );

    function automatic logic [31:0] mk(input logic le, input logic tmo, input logic be,
                                       input logic [2:0] sz, input logic s,
                                       input logic me, input logic rd, input logic fav);
        return {le | tmo | be, le, tmo, be, sz, s, 4'h8, me, rd, fav, 17'd0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cpl(input logic [1:0] k, input logic [2:0] sz, input logic s,
                       input logic rd, input logic [31:0] a);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_kind = k; cpl_size = sz; cpl_super = s;
        cpl_read = rd; cpl_addr = a;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    task automatic clr();
        @(negedge clk); sw_wr = 1'b1;
        @(negedge clk); sw_wr = 1'b0;
    endtask

    task automatic start(input logic [2:0] sz, input logic s, input logic [31:0] a);
        @(negedge clk);
        wr_start = 1'b1; wr_size = sz; wr_super = s; wr_addr = a;
        @(negedge clk);
        wr_start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset status", status, 32'h0080_0000);
        check("R1 reset addr", fault_addr, 32'd0);
        check("R1 reset irq", {31'd0, irq}, 32'd0);

        // R3 R4 R8 R9: sweep of completion events
        for (int k = 0; k < 4; k++)
            for (int sz = 0; sz < 8; sz++)
                for (int s = 0; s < 2; s++)
                    for (int r = 0; r < 2; r++) begin
                        logic [31:0] a;
                        logic fault;
                        a = 32'h1000_0000 + 32'(k * 4096 + sz * 64 + s * 8 + r * 4);
                        fault = (k == 1) || (k == 2);
                        cpl(2'(k), 3'(sz), 1'(s), 1'(r), a);
                        if (fault) begin
                            last_addr = a;
                            check("R3 R4 status", status,
                                  mk(k == 1, 1'b0, k == 2, 3'(sz), 1'(s), 1'b0, 1'(r), 1'b1));
                            check("R4 addr", fault_addr, a);
                            check("R9 irq set", {31'd0, irq}, 32'd1);
                        end else begin
                            check("R3 no fault", status, 32'h0080_0000);
                            check("R9 irq clear", {31'd0, irq}, 32'd0);
                        end
                        clr();
                        check("R8 cleared", status, 32'h0080_0000);
                        check("R8 addr kept", fault_addr, last_addr);
                    end

        // R5: no completion, timeout on the limit edge exactly
        start(3'd5, 1'b1, 32'h2222_0000);
        repeat (LIM - 1) @(negedge clk);
        check("R5 before limit", status, 32'h0080_0000);
        @(negedge clk);
        check("R5 timeout", status, mk(1'b0, 1'b1, 1'b0, 3'd5, 1'b1, 1'b0, 1'b0, 1'b1));
        check("R5 timeout addr", fault_addr, 32'h2222_0000);
        last_addr = 32'h2222_0000;
        repeat (LIM + 2) @(negedge clk);
        check("R5 single fire", status, mk(1'b0, 1'b1, 1'b0, 3'd5, 1'b1, 1'b0, 1'b0, 1'b1));
        clr();

        // R6: write completion on edge g = 1..LIM prevents the timeout
        for (int g = 1; g <= LIM; g++) begin
            start(3'd2, 1'b0, 32'h3300_0000 + 32'(g));
            repeat (g - 1) @(negedge clk);
            cpl_valid = 1'b1; cpl_kind = 2'b00; cpl_read = 1'b0;
            @(negedge clk);
            cpl_valid = 1'b0;
            repeat (LIM + 2) @(negedge clk);
            check("R6 ended write no timeout", status, 32'h0080_0000);
        end

        // R6: a read completion does not end the write
        start(3'd1, 1'b0, 32'h4400_0000);
        cpl(2'b00, 3'd0, 1'b0, 1'b1, 32'h0);
        repeat (LIM - 2) @(negedge clk);
        check("R6 read keeps timer", status,
              mk(1'b0, 1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1));
        clr();

        // R6: restart moves the deadline and attributes
        start(3'd1, 1'b0, 32'h4500_0000);
        repeat (LIM - 2) @(negedge clk);
        start(3'd6, 1'b1, 32'h4600_0000);
        repeat (LIM - 1) @(negedge clk);
        check("R6 restart no early fire", status, 32'h0080_0000);
        @(negedge clk);
        check("R6 restart attrs", status, mk(1'b0, 1'b1, 1'b0, 3'd6, 1'b1, 1'b0, 1'b0, 1'b1));
        check("R6 restart addr", fault_addr, 32'h4600_0000);
        clr();

        // R7: later faults only set the multiple flag
        cpl(2'b01, 3'd3, 1'b1, 1'b0, 32'h5500_0010);
        cpl(2'b10, 3'd7, 1'b0, 1'b1, 32'h5500_0020);
        check("R7 second fault", status, mk(1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 1'b1, 1'b0, 1'b1));
        check("R7 addr first", fault_addr, 32'h5500_0010);
        clr();
        cpl(2'b10, 3'd4, 1'b0, 1'b1, 32'h5600_0000);
        start(3'd1, 1'b1, 32'h5700_0000);
        repeat (LIM) @(negedge clk);
        check("R7 timeout after record", status,
              mk(1'b0, 1'b0, 1'b1, 3'd4, 1'b0, 1'b1, 1'b1, 1'b1));
        clr();

        // R7: completion fault and timeout on the same edge
        start(3'd2, 1'b0, 32'h5800_0000);
        repeat (LIM - 1) @(negedge clk);
        cpl_valid = 1'b1; cpl_kind = 2'b01; cpl_size = 3'd6; cpl_super = 1'b1;
        cpl_read = 1'b1; cpl_addr = 32'h5900_0000;
        @(negedge clk);
        cpl_valid = 1'b0;
        check("R7 simultaneous", status, mk(1'b1, 1'b0, 1'b0, 3'd6, 1'b1, 1'b1, 1'b1, 1'b1));
        check("R7 simultaneous addr", fault_addr, 32'h5900_0000);

        // R8: clear and fault at the same edge keep the new fault as first
        @(negedge clk);
        sw_wr = 1'b1;
        cpl_valid = 1'b1; cpl_kind = 2'b10; cpl_size = 3'd3; cpl_super = 1'b0;
        cpl_read = 1'b0; cpl_addr = 32'h6000_0000;
        @(negedge clk);
        sw_wr = 1'b0; cpl_valid = 1'b0;
        check("R8 clear with fault", status, mk(1'b0, 1'b0, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1));
        check("R8 clear with fault addr", fault_addr, 32'h6000_0000);
        clr();
        check("R8 final clear", status, 32'h0080_0000);
        check("R8 addr survives", fault_addr, 32'h6000_0000);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule